// File: doc/BRIEF.md
# Task Switch Sequencer

This block is a multi-cycle controller that moves a processor from the task it is running to a new task. A request names its source: jump, call, call through a task gate, interrupt through a task gate, or return from a nested task. It also carries a selector, the current privilege level (CPL) and the requestor privilege level (RPL). The controller reads descriptors from a table in memory and decides whether the switch is allowed. It then writes the live register context into the outgoing task's state segment and updates the busy bits and the back-link word. After that it loads the task register and reads the incoming context back, one word per cycle. Two more commands work on the task register alone. One loads the task register and is privileged. The other reads it back and is open to every level.

Memory is reached through one 32-bit word port with combinational read data. A descriptor takes two words at `tbl_base + 8*(selector>>3)`. Word 0 holds the segment base; for a gate, it holds the target selector in bits 15:0. Word 1 holds the attributes: bit 31 present, bits 30:29 DPL, bit 28 busy, bit 27 gate, bits 19:0 limit. A state segment holds its back-link selector in word 0. Context word i sits at byte offset 4+4i, in the order instruction pointer, flags, eight general registers, then six segment selectors.

The FSM has these states: `S_IDLE`, `S_LINK_RD`, `S_GATE_HI`, `S_GATE_LO`, `S_DESC_HI`, `S_DESC_LO`, `S_SAVE`, `S_OLD_RD`, `S_OLD_WR`, `S_NEW_BUSY`, `S_LINK_WR`, `S_CACHE`, `S_RESTORE`, `S_DONE`, `S_FAULT` and `S_STR`.
- From `S_IDLE`, a request leaves as follows:
  - return goes to `S_LINK_RD`;
  - gate call and interrupt go to `S_GATE_HI`;
  - jump, call and a level-0 task-register load go to `S_DESC_HI`;
  - a load at any other level goes to `S_FAULT`;
  - a store goes to `S_STR`.
- `S_LINK_RD` goes to `S_DESC_HI`.
- `S_GATE_HI` goes to `S_GATE_LO`, or to `S_FAULT` if the gate fails its checks. `S_GATE_LO` goes to `S_DESC_HI`.
- `S_DESC_HI` goes to `S_DESC_LO`, or to `S_FAULT` if the descriptor fails its checks. `S_DESC_LO` goes to `S_CACHE` for a load and to `S_SAVE` otherwise.
- `S_SAVE` repeats until the last context word. It then goes to `S_OLD_RD` for jump or return, and to `S_NEW_BUSY` for the other sources. `S_OLD_RD` goes to `S_OLD_WR`, and `S_OLD_WR` goes to `S_NEW_BUSY`.
- `S_NEW_BUSY` goes to `S_LINK_WR` on a nesting switch and to `S_CACHE` otherwise. `S_LINK_WR` goes to `S_CACHE`.
- `S_CACHE` goes to `S_DONE` for a load and to `S_RESTORE` otherwise. `S_RESTORE` repeats until the last word, then goes to `S_DONE`.
- `S_DONE`, `S_FAULT` and `S_STR` each last one cycle and return to `S_IDLE`.
- Requests are sampled only in `S_IDLE`.

Top module: `tswitch_seq`

## Requirements
- R1: For a jump (kind 0) or call (kind 1), the target descriptor's DPL must be greater than or equal to max(CPL, RPL). Otherwise the switch faults with the target selector.
- R2: For a gate call (kind 2), the gate's DPL is checked against max(CPL, RPL) and the target descriptor's DPL is ignored. A failed check faults with the gate selector.
- R3: An interrupt (kind 3) and a nested return (kind 4) perform no privilege check at any stage.
- R4: A switch whose target is not present, is a gate, or has a limit below 103 faults with the target selector. So does a gate-stage descriptor that is not present or is not a gate.
- R5: A fault gives a one-cycle `fault` pulse with `fault_sel` set to the offending selector. No memory write takes place and the task register does not change.
- R6: The context is written one word per cycle to the old task-register base + 4 + 4i for i = 0..15. Word 0 is `req_next_ip` and word i>0 is live register i.
- R7: Call, gate call and interrupt write the old task-register selector into word 0 of the new state segment and set bit 14 of the restored flags word (index 1). Jump and return do neither.
- R8: After the save, the new descriptor's attribute word is written back with bit 28 set. The task register then holds the new selector, base and limit, with `msw_ts` set.
- R9: Jump and return write the old descriptor's attribute word back with bit 28 cleared. Call, gate call and interrupt leave it untouched.
- R10: The new context is read from new base + 4 + 4i. It is presented one word per cycle on `ctx_wr_*` in index order 0..15, and `done` pulses for one cycle in the cycle after the last word.
- R11: A nested return takes its target selector from word 0 of the current state segment.
- R12: A task-register load (kind 5) succeeds only at CPL 0. It loads selector, base and limit without any memory write and with `msw_ts` untouched; at any other CPL it faults. A store (kind 6) at any CPL pulses `str_valid` with `str_sel` equal to the current selector and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, sampled in idle |
| req_kind | input | 3 | 0 jump, 1 call, 2 gate call, 3 interrupt, 4 return, 5 load TR, 6 store TR |
| req_sel | input | 16 | Request selector |
| req_cpl | input | 2 | Current privilege level |
| req_rpl | input | 2 | Requestor privilege level |
| req_next_ip | input | 32 | Address of the instruction after the trigger |
| tbl_base | input | 32 | Descriptor table base address |
| ctx_rd_idx | output | 4 | Live register index being saved |
| ctx_rd_data | input | 32 | Live register value at `ctx_rd_idx` |
| ctx_wr_en | output | 1 | Restored context word valid |
| ctx_wr_idx | output | 4 | Restored context word index |
| ctx_wr_data | output | 32 | Restored context word |
| mem_en | output | 1 | Memory access |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Combinational read data |
| tr_sel | output | 16 | Task register visible selector |
| tr_base | output | 32 | Task register cached base |
| tr_limit | output | 20 | Task register cached limit |
| msw_ts | output | 1 | Task-switched status bit |
| done | output | 1 | Operation complete pulse |
| fault | output | 1 | Fault pulse |
| fault_sel | output | 16 | Offending selector |
| str_valid | output | 1 | Store response pulse |
| str_sel | output | 16 | Stored selector |

## Verification
Two things happen in the same cycle, `S_NEW_BUSY`. The incoming descriptor's busy bit is written to memory while the visible selector and the task-switched bit are loaded. On jumps and returns, that write also follows directly after the outgoing descriptor's busy bit is cleared. Every successful switch provokes this, including a jump, a return and a switch back onto a task whose descriptor was left busy. A behavioural model predicts, in order, each memory write's address and data and each restored context word. These are compared as they appear on every clock. The task-register outputs are compared with the model when each operation completes.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

    typedef enum logic [2:0] {
        K_JMP  = 3'd0,
        K_CALL = 3'd1,
        K_GATE = 3'd2,
        K_INTR = 3'd3,
        K_IRET = 3'd4,
        K_LTR  = 3'd5,
        K_STR  = 3'd6
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_LINK_RD, S_GATE_HI, S_GATE_LO, S_DESC_HI, S_DESC_LO,
        S_SAVE, S_OLD_RD, S_OLD_WR, S_NEW_BUSY, S_LINK_WR, S_CACHE,
        S_RESTORE, S_DONE, S_FAULT, S_STR
    } state_e;

    // attribute-word bit positions
    localparam int D_PRES = 31;
    localparam int D_DPL  = 29;
    localparam int D_BUSY = 28;
    localparam int D_GATE = 27;
    // nested-task flag position in the flags word
    localparam int NT_BIT = 14;

    function automatic logic is_nest(input kind_e k);
        return (k == K_CALL) || (k == K_GATE) || (k == K_INTR);
    endfunction

    function automatic logic is_unnest(input kind_e k);
        return (k == K_JMP) || (k == K_IRET);
    endfunction

endpackage

// File: rtl/tsw_priv_chk.sv
module tsw_priv_chk
    import tsw_pkg::*;
(
    input  kind_e      kind,
    input  logic       gate_stage,
    input  logic [1:0] dpl,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    output logic       ok
);
    logic       need;
    logic [1:0] eff;

    always_comb begin
        need = gate_stage ? (kind == K_GATE)
                          : ((kind == K_JMP) || (kind == K_CALL));
        eff  = (cpl > rpl) ? cpl : rpl;
        ok   = !need || (dpl >= eff);
    end
endmodule

// File: rtl/tsw_treg.sv
module tsw_treg #(
    parameter int SEL_W = 16,
    parameter int AW    = 32,
    parameter int LIM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_sel,
    input  logic             set_ts,
    input  logic [SEL_W-1:0] sel_d,
    input  logic             ld_cache,
    input  logic [AW-1:0]    base_d,
    input  logic [LIM_W-1:0] limit_d,
    output logic [SEL_W-1:0] sel_q,
    output logic [AW-1:0]    base_q,
    output logic [LIM_W-1:0] limit_q,
    output logic             ts_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            base_q  <= '0;
            limit_q <= '0;
            ts_q    <= 1'b0;
        end else begin
            if (ld_sel)   sel_q <= sel_d;
            if (set_ts)   ts_q  <= 1'b1;
            if (ld_cache) begin
                base_q  <= base_d;
                limit_q <= limit_d;
            end
        end
    end
endmodule

// File: rtl/tswitch_seq.sv
module tswitch_seq
    import tsw_pkg::*;
#(
    parameter int SEL_W     = 16,
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int LIM_W     = 20,
    parameter int CTX_WORDS = 16,
    parameter int MIN_LIMIT = 103
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [2:0]                   req_kind,
    input  logic [SEL_W-1:0]             req_sel,
    input  logic [1:0]                   req_cpl,
    input  logic [1:0]                   req_rpl,
    input  logic [AW-1:0]                req_next_ip,
    input  logic [AW-1:0]                tbl_base,
    output logic [$clog2(CTX_WORDS)-1:0] ctx_rd_idx,
    input  logic [DW-1:0]                ctx_rd_data,
    output logic                         ctx_wr_en,
    output logic [$clog2(CTX_WORDS)-1:0] ctx_wr_idx,
    output logic [DW-1:0]                ctx_wr_data,
    output logic                         mem_en,
    output logic                         mem_we,
    output logic [AW-1:0]                mem_addr,
    output logic [DW-1:0]                mem_wdata,
    input  logic [DW-1:0]                mem_rdata,
    output logic [SEL_W-1:0]             tr_sel,
    output logic [AW-1:0]                tr_base,
    output logic [LIM_W-1:0]             tr_limit,
    output logic                         msw_ts,
    output logic                         done,
    output logic                         fault,
    output logic [SEL_W-1:0]             fault_sel,
    output logic                         str_valid,
    output logic [SEL_W-1:0]             str_sel
);
    localparam int IDX_W = $clog2(CTX_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CTX_WORDS - 1);
    localparam logic [IDX_W-1:0] FLAGS_IDX = IDX_W'(1);

    state_e state, nxt;

    kind_e            r_kind;
    logic [SEL_W-1:0] r_sel, r_tsel, r_oldsel, r_fsel;
    logic [1:0]       r_cpl, r_rpl;
    logic [AW-1:0]    r_nip, r_base;
    logic [DW-1:0]    r_d1, r_old1;
    logic [IDX_W-1:0] r_idx;

    logic priv_ok, gate_ok, desc_ok;
    logic ld_sel, set_ts, ld_cache;

    function automatic logic [AW-1:0] dsc(input logic [SEL_W-1:0] s);
        return tbl_base + AW'({s[SEL_W-1:3], 3'b000});
    endfunction

    function automatic logic [AW-1:0] ctx_addr(input logic [AW-1:0] b,
                                               input logic [IDX_W-1:0] i);
        return b + AW'(4) + AW'({i, 2'b00});
    endfunction

    tsw_priv_chk u_priv (
        .kind       (r_kind),
        .gate_stage (state == S_GATE_HI),
        .dpl        (mem_rdata[D_DPL+1:D_DPL]),
        .cpl        (r_cpl),
        .rpl        (r_rpl),
        .ok         (priv_ok)
    );

    tsw_treg #(.SEL_W(SEL_W), .AW(AW), .LIM_W(LIM_W)) u_treg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_sel   (ld_sel),
        .set_ts   (set_ts),
        .sel_d    (r_tsel),
        .ld_cache (ld_cache),
        .base_d   (r_base),
        .limit_d  (r_d1[LIM_W-1:0]),
        .sel_q    (tr_sel),
        .base_q   (tr_base),
        .limit_q  (tr_limit),
        .ts_q     (msw_ts)
    );

    always_comb begin
        gate_ok = mem_rdata[D_PRES] && mem_rdata[D_GATE] && priv_ok;
        desc_ok = mem_rdata[D_PRES] && !mem_rdata[D_GATE] &&
                  (mem_rdata[LIM_W-1:0] >= LIM_W'(MIN_LIMIT)) && priv_ok;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (req_valid) begin
                case (kind_e'(req_kind))
                    K_STR:          nxt = S_STR;
                    K_LTR:          nxt = (req_cpl == 2'd0) ? S_DESC_HI : S_FAULT;
                    K_IRET:         nxt = S_LINK_RD;
                    K_GATE, K_INTR: nxt = S_GATE_HI;
                    K_JMP, K_CALL:  nxt = S_DESC_HI;
                    default:        nxt = S_IDLE;
                endcase
            end
            S_LINK_RD:  nxt = S_DESC_HI;
            S_GATE_HI:  nxt = gate_ok ? S_GATE_LO : S_FAULT;
            S_GATE_LO:  nxt = S_DESC_HI;
            S_DESC_HI:  nxt = desc_ok ? S_DESC_LO : S_FAULT;
            S_DESC_LO:  nxt = (r_kind == K_LTR) ? S_CACHE : S_SAVE;
            S_SAVE:     if (r_idx == LAST_IDX)
                            nxt = is_unnest(r_kind) ? S_OLD_RD : S_NEW_BUSY;
            S_OLD_RD:   nxt = S_OLD_WR;
            S_OLD_WR:   nxt = S_NEW_BUSY;
            S_NEW_BUSY: nxt = is_nest(r_kind) ? S_LINK_WR : S_CACHE;
            S_LINK_WR:  nxt = S_CACHE;
            S_CACHE:    nxt = (r_kind == K_LTR) ? S_DONE : S_RESTORE;
            S_RESTORE:  if (r_idx == LAST_IDX) nxt = S_DONE;
            S_DONE, S_FAULT, S_STR: nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_wdata   = '0;
        ctx_rd_idx  = r_idx;
        ctx_wr_en   = 1'b0;
        ctx_wr_idx  = r_idx;
        ctx_wr_data = mem_rdata;
        ld_sel      = 1'b0;
        set_ts      = 1'b0;
        ld_cache    = 1'b0;
        done        = 1'b0;
        fault       = 1'b0;
        str_valid   = 1'b0;
        unique case (state)
            S_LINK_RD: begin
                mem_en   = 1'b1;
                mem_addr = tr_base;
            end
            S_GATE_HI: begin
                mem_en   = 1'b1;
                mem_addr = dsc(r_sel) + AW'(4);
            end
            S_GATE_LO: begin
                mem_en   = 1'b1;
                mem_addr = dsc(r_sel);
            end
            S_DESC_HI: begin
                mem_en   = 1'b1;
                mem_addr = dsc(r_tsel) + AW'(4);
            end
            S_DESC_LO: begin
                mem_en   = 1'b1;
                mem_addr = dsc(r_tsel);
            end
            S_SAVE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_addr(tr_base, r_idx);
                mem_wdata = (r_idx == '0) ? DW'(r_nip) : ctx_rd_data;
            end
            S_OLD_RD: begin
                mem_en   = 1'b1;
                mem_addr = dsc(tr_sel) + AW'(4);
            end
            S_OLD_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dsc(tr_sel) + AW'(4);
                mem_wdata = r_old1 & ~(DW'(1) << D_BUSY);
            end
            S_NEW_BUSY: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dsc(r_tsel) + AW'(4);
                mem_wdata = r_d1 | (DW'(1) << D_BUSY);
                ld_sel    = 1'b1;
                set_ts    = 1'b1;
            end
            S_LINK_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_base;
                mem_wdata = DW'(r_oldsel);
            end
            S_CACHE: begin
                ld_cache = 1'b1;
                ld_sel   = (r_kind == K_LTR);
            end
            S_RESTORE: begin
                mem_en    = 1'b1;
                mem_addr  = ctx_addr(r_base, r_idx);
                ctx_wr_en = 1'b1;
                if (r_idx == FLAGS_IDX && is_nest(r_kind))
                    ctx_wr_data = mem_rdata | (DW'(1) << NT_BIT);
            end
            S_DONE:  done      = 1'b1;
            S_FAULT: fault     = 1'b1;
            S_STR:   str_valid = 1'b1;
            default: ;
        endcase
    end

    assign fault_sel = r_fsel;
    assign str_sel   = tr_sel;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_kind   <= K_JMP;
            r_sel    <= '0;
            r_tsel   <= '0;
            r_oldsel <= '0;
            r_fsel   <= '0;
            r_cpl    <= '0;
            r_rpl    <= '0;
            r_nip    <= '0;
            r_base   <= '0;
            r_d1     <= '0;
            r_old1   <= '0;
            r_idx    <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    r_kind   <= kind_e'(req_kind);
                    r_sel    <= req_sel;
                    r_tsel   <= req_sel;
                    r_fsel   <= req_sel;
                    r_oldsel <= tr_sel;
                    r_cpl    <= req_cpl;
                    r_rpl    <= req_rpl;
                    r_nip    <= req_next_ip;
                    r_idx    <= '0;
                end
                S_LINK_RD: r_tsel <= mem_rdata[SEL_W-1:0];
                S_GATE_HI: r_fsel <= r_sel;
                S_GATE_LO: r_tsel <= mem_rdata[SEL_W-1:0];
                S_DESC_HI: begin
                    r_fsel <= r_tsel;
                    r_d1   <= mem_rdata;
                end
                S_DESC_LO: r_base <= mem_rdata[AW-1:0];
                S_SAVE, S_RESTORE:
                    r_idx <= (r_idx == LAST_IDX) ? '0 : r_idx + 1'b1;
                S_OLD_RD: r_old1 <= mem_rdata;
                default: ;
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    fault_tr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(tr_sel) && $stable(tr_base)));

    // R5
    resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault, str_valid}));

    // R12
    str_tr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        str_valid |-> ($stable(tr_sel) && $stable(tr_limit)));

    // R6
    save_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SAVE && $past(state) == S_SAVE) |->
            (mem_addr == $past(mem_addr) + AW'(4)));

    // R8
    switch_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_kind != K_LTR) |-> msw_ts);

endmodule

// File: tb/tswitch_seq_bench.sv
module tswitch_seq_bench;
    import tsw_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n, req_valid;
    logic [2:0]  req_kind;
    logic [15:0] req_sel;
    logic [1:0]  req_cpl, req_rpl;
    logic [31:0] req_next_ip, tbl_base;
    logic [3:0]  ctx_rd_idx, ctx_wr_idx;
    logic [31:0] ctx_rd_data, ctx_wr_data;
    logic        ctx_wr_en, mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] tr_sel, fault_sel, str_sel;
    logic [31:0] tr_base;
    logic [19:0] tr_limit;
    logic        msw_ts, done, fault, str_valid;

    tswitch_seq u_tswitch_seq (.*);

    logic [31:0] mem  [0:1023];
    logic [31:0] live [0:15];
    assign mem_rdata   = mem[mem_addr[11:2]];
    assign ctx_rd_data = live[ctx_rd_idx];
    always @(posedge clk) if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_wa[$], exp_wd[$], exp_rd[$];
    int          exp_ri[$];
    logic [15:0] m_sel = 0;
    logic [31:0] m_base = 0;
    logic [19:0] m_lim = 0;
    logic        m_ts = 0;
    int          nip_ctr = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-clock comparison of the write and restore streams
    always @(negedge clk) if (rst_n) begin
        if (mem_we) begin
            if (exp_wa.size() == 0)
                chk("R5", "unexpected write addr", mem_addr, 32'hxxxx_dead);
            else begin
                chk("R6 R7 R8 R9", "write addr", mem_addr, exp_wa.pop_front());
                chk("R6 R7 R8 R9", "write data", mem_wdata, exp_wd.pop_front());
            end
        end
        if (ctx_wr_en) begin
            if (exp_rd.size() == 0)
                chk("R10", "unexpected restore", {28'd0, ctx_wr_idx}, 32'hffff_ffff);
            else begin
                chk("R10", "restore idx", {28'd0, ctx_wr_idx}, exp_ri.pop_front());
                chk("R10 R7", "restore data", ctx_wr_data, exp_rd.pop_front());
            end
        end
    end

    function automatic logic [31:0] mk(bit p, logic [1:0] dpl, bit busy, bit gate, logic [19:0] lim);
        return {p, dpl, busy, gate, 7'd0, lim};
    endfunction

    function automatic int dw(logic [15:0] s);
        return int'(s >> 3) * 2;
    endfunction

    bit got_done, got_fault, got_str;
    logic [15:0] cap_fsel, cap_ssel;

    task automatic issue(logic [2:0] k, logic [15:0] s, logic [1:0] c, logic [1:0] r, logic [31:0] nip);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_sel = s;
        req_cpl = c; req_rpl = r; req_next_ip = nip;
        @(negedge clk);
        req_valid = 1'b0;
        got_done = 0; got_fault = 0; got_str = 0;
        for (int c2 = 0; c2 < 100; c2++) begin
            if (done || fault || str_valid) begin
                got_done = done; got_fault = fault; got_str = str_valid;
                cap_fsel = fault_sel; cap_ssel = str_sel;
                break;
            end
            @(negedge clk);
        end
        if (!(got_done || got_fault || got_str)) begin
            n_cmp++; n_bad++;
            $display("FAIL %s timeout actual=none expected=response", "R10");
        end
        @(negedge clk);
    endtask

    task automatic chk_tr(string tag);
        chk(tag, "tr_sel", {16'd0, tr_sel}, {16'd0, m_sel});
        chk(tag, "tr_base", tr_base, m_base);
        chk(tag, "tr_limit", {12'd0, tr_limit}, {12'd0, m_lim});
        chk(tag, "msw_ts", {31'd0, msw_ts}, {31'd0, m_ts});
        chk(tag, "queues drained", exp_wa.size() + exp_rd.size(), 0);
    endtask

    task automatic run_switch(kind_e k, logic [15:0] s, logic [1:0] c, logic [1:0] r, string tag);
        bit flt = 0;
        logic [15:0] tsel = s, fsel = 0;
        logic [31:0] g1, d0, d1, nip;
        logic [1:0]  mx = (c > r) ? c : r;
        bit nest = (k == K_CALL) || (k == K_GATE) || (k == K_INTR);
        nip_ctr++;
        nip = 32'h1000_0000 + nip_ctr;
        for (int i = 0; i < 16; i++) live[i] = {8'hC0 + nip_ctr[7:0], 16'd0, 8'(i)};
        if (k == K_IRET) tsel = mem[m_base >> 2][15:0];
        else if (k == K_GATE || k == K_INTR) begin
            g1 = mem[dw(s) + 1];
            if (!g1[31] || !g1[27] || (k == K_GATE && g1[30:29] < mx)) begin
                flt = 1; fsel = s;
            end else tsel = mem[dw(s)][15:0];
        end
        if (!flt) begin
            d1 = mem[dw(tsel) + 1];
            d0 = mem[dw(tsel)];
            if (!d1[31] || d1[27] || d1[19:0] < 20'd103 ||
                ((k == K_JMP || k == K_CALL) && d1[30:29] < mx)) begin
                flt = 1; fsel = tsel;
            end
        end
        if (!flt) begin
            for (int i = 0; i < 16; i++) begin
                exp_wa.push_back(m_base + 4 + 4 * i);
                exp_wd.push_back(i == 0 ? nip : live[i]);
            end
            if (!nest) begin
                exp_wa.push_back(dw(m_sel) * 4 + 4);
                exp_wd.push_back(mem[dw(m_sel) + 1] & ~(32'd1 << 28));
            end
            exp_wa.push_back(dw(tsel) * 4 + 4);
            exp_wd.push_back(d1 | (32'd1 << 28));
            if (nest) begin
                exp_wa.push_back(d0);
                exp_wd.push_back({16'd0, m_sel});
            end
            for (int i = 0; i < 16; i++) begin
                exp_ri.push_back(i);
                exp_rd.push_back(mem[(d0 >> 2) + 1 + i] | ((nest && i == 1) ? 32'h4000 : 32'h0));
            end
        end
        issue(k, s, c, r, nip);
        if (flt) begin
            chk(tag, "fault pulse", {31'd0, got_fault}, 1);
            chk(tag, "fault_sel", {16'd0, cap_fsel}, {16'd0, fsel});
        end else begin
            chk(tag, "done pulse", {31'd0, got_done}, 1);
            m_sel = tsel; m_base = d0; m_lim = d1[19:0]; m_ts = 1;
        end
        chk_tr(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_kind = 0; req_sel = 0;
        req_cpl = 0; req_rpl = 0; req_next_ip = 0; tbl_base = 0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5000_0000 | i;
        for (int i = 0; i < 16; i++) live[i] = 0;
        mem[dw(16'h08)] = 32'h200; mem[dw(16'h08) + 1] = mk(1, 0, 1, 0, 103);
        mem[dw(16'h10)] = 32'h300; mem[dw(16'h10) + 1] = mk(1, 3, 0, 0, 200);
        mem[dw(16'h18)] = 32'h380; mem[dw(16'h18) + 1] = mk(1, 0, 0, 0, 103);
        mem[dw(16'h20)] = 32'h18;  mem[dw(16'h20) + 1] = mk(1, 3, 0, 1, 0);
        mem[dw(16'h28)] = 32'h18;  mem[dw(16'h28) + 1] = mk(1, 0, 0, 1, 0);
        mem[dw(16'h30)] = 32'h400; mem[dw(16'h30) + 1] = mk(0, 3, 0, 0, 103);
        mem[dw(16'h38)] = 32'h400; mem[dw(16'h38) + 1] = mk(1, 3, 0, 0, 50);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R8", "reset done/fault", {30'd0, done, fault}, 0);
        chk_tr("R8 reset");

        // R12 load at CPL 3 refused, then at CPL 0 accepted
        issue(K_LTR, 16'h08, 2'd3, 2'd0, 0);
        chk("R12", "ltr fault", {31'd0, got_fault}, 1);
        chk("R12", "ltr fault_sel", {16'd0, cap_fsel}, 32'h08);
        chk_tr("R12");
        issue(K_LTR, 16'h08, 2'd0, 2'd0, 0);
        chk("R12", "ltr done", {31'd0, got_done}, 1);
        m_sel = 16'h08; m_base = 32'h200; m_lim = 20'd103;
        chk_tr("R12");
        issue(K_STR, 16'h0, 2'd3, 2'd3, 0);
        chk("R12", "str_valid", {31'd0, got_str}, 1);
        chk("R12", "str_sel", {16'd0, cap_ssel}, 32'h08);
        chk_tr("R12");

        run_switch(K_JMP,  16'h18, 2'd3, 2'd0, "R1 R5 cpl");
        run_switch(K_JMP,  16'h18, 2'd0, 2'd3, "R1 R5 rpl");
        run_switch(K_JMP,  16'h10, 2'd3, 2'd0, "R1 R6 R8 R9 jump");
        run_switch(K_GATE, 16'h28, 2'd3, 2'd0, "R2 R5 gate dpl");
        run_switch(K_GATE, 16'h20, 2'd3, 2'd3, "R2 R7 gate ok");
        run_switch(K_IRET, 16'h00, 2'd3, 2'd3, "R11 R3 R9 return");
        run_switch(K_INTR, 16'h28, 2'd3, 2'd3, "R3 R7 interrupt");
        run_switch(K_JMP,  16'h30, 2'd0, 2'd0, "R4 not present");
        run_switch(K_JMP,  16'h38, 2'd3, 2'd0, "R4 short limit");
        run_switch(K_CALL, 16'h08, 2'd0, 2'd0, "R7 R9 R10 call");

        issue(K_STR, 16'h0, 2'd2, 2'd1, 0);
        chk("R12", "str_sel end", {16'd0, cap_ssel}, {16'd0, m_sel});
        chk_tr("R12");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule